// File: doc/BRIEF.md
# Predicated 24-bit Accumulator Shifter

The block holds a small bank of 24-bit accumulators and a carry flag. On a shift command it reads one accumulator, shifts it by one or eight places in either direction in a single cycle, and writes the result and the carry flag. The source and destination accumulators are chosen independently. Every shift is predicated on a T flag input. When that flag is low, the command is dropped and no state changes.

Plain shifts are arithmetic. A right shift replicates the sign bit into the vacated high bits, and a left shift inserts zeros at the low end. In carry mode, the vacated bits take the carry value held before the shift. In both modes, the carry flag ends holding the last bit shifted out.

A load port writes an accumulator and a separate input sets the carry flag. A combinational read port exposes any accumulator, and the carry flag is a direct output. Together these let the surrounding datapath seed operands, for example to chain shifts across words through the carry.

Top module: `shf_unit`

## Requirements
- R1: After reset, every accumulator reads 0 and `carry` is 0.
- R2: With `ld_en` high at a clock edge, accumulator `ld_sel` holds `ld_data` after that edge. `rd_data` always shows accumulator `rd_sel` combinationally.
- R3: A plain right shift (`sh_left`=0, `sh_thru`=0) writes the source shifted right by 1 (`sh_by8`=0) or by 8 (`sh_by8`=1). Every vacated high bit is a copy of source bit 23.
- R4: A plain left shift (`sh_left`=1, `sh_thru`=0) writes the source shifted left by 1 or 8 and fills the vacated low bits with 0.
- R5: After any executed shift by n places, `carry` holds the last bit shifted out. That bit is source bit n-1 for a right shift and source bit 24-n for a left shift.
- R6: In carry mode (`sh_thru`=1), every vacated bit takes the value `carry` had before the shift. For a 1-place shift, the old carry lands in bit 0 (left) or bit 23 (right).
- R7: A shift whose command is sampled at one clock edge is complete after that same edge. A second shift issued on the next edge acts on the first result.
- R8: With `sh_en`=1 and `t_flag`=0, no accumulator and no carry value change.
- R9: Only the destination accumulator is written. A source different from the destination keeps its value.
- R10: If a shift executes and a load targets the same accumulator in the same cycle, the shift result is stored. If the targets differ, both writes take place.
- R11: With `c_ld_en` high, `carry` takes `c_ld_val` at the edge. An executed shift in the same cycle overrides it with its shifted-out bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_en | input | 1 | Load an accumulator |
| ld_sel | input | 2 | Accumulator to load |
| ld_data | input | 24 | Load value |
| c_ld_en | input | 1 | Load the carry flag |
| c_ld_val | input | 1 | Carry load value |
| sh_en | input | 1 | Shift command present |
| t_flag | input | 1 | Predicate; a shift executes only when high |
| sh_src | input | 2 | Source accumulator |
| sh_dst | input | 2 | Destination accumulator |
| sh_left | input | 1 | 1 = left, 0 = right |
| sh_by8 | input | 1 | 1 = eight places, 0 = one place |
| sh_thru | input | 1 | 1 = carry mode, 0 = plain |
| rd_sel | input | 2 | Accumulator shown on rd_data |
| rd_data | output | 24 | Selected accumulator value |
| carry | output | 1 | Carry flag |

## Verification
The hardest cases to reach are the carry-mode fills. They need a known old carry to meet a source value whose edge bits differ from that carry, in every direction and at both distances. The bench sets the carry through the carry load input just before each shift, covering both carry values. It sweeps source patterns that include sign-only, all-ones, all-but-sign and single-LSB words across all eight command combinations. It also issues same-cycle load/shift and carry-load/shift collisions to reach the priority cases.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int ACC_W   = 24;
  localparam int ACC_N   = 4;
  localparam int DIST_S  = 1;
  localparam int DIST_L  = 8;

  typedef struct packed {
    logic left;
    logic by8;
    logic thru;
  } shf_cmd_t;
endpackage

// File: rtl/shf_rst_sync.sv
module shf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
  import shf_pkg::*;
#(
  parameter int W      = ACC_W,
  parameter int D_SHRT = DIST_S,
  parameter int D_LONG = DIST_L
) (
  input  logic [W-1:0] src,
  input  logic         cin,
  input  shf_cmd_t     cmd,
  output logic [W-1:0] res,
  output logic         cout
);
  logic [W-1:0] res_v [2];
  logic         co_v  [2];

  logic fill_hi;
  logic fill_lo;

  always_comb begin
    fill_hi = cmd.thru ? cin : src[W-1];
    fill_lo = cmd.thru & cin;
  end

  for (genvar d = 0; d < 2; d++) begin : g_dist
    localparam int D = (d == 0) ? D_SHRT : D_LONG;
    logic [W-1:0] r_right;
    logic [W-1:0] r_left;
    always_comb begin
      r_right = {{D{fill_hi}}, src[W-1:D]};
      r_left  = {src[W-1-D:0], {D{fill_lo}}};
      res_v[d] = cmd.left ? r_left : r_right;
      co_v[d]  = cmd.left ? src[W-D] : src[D-1];
    end
  end

  always_comb begin
    res  = cmd.by8 ? res_v[1] : res_v[0];
    cout = cmd.by8 ? co_v[1]  : co_v[0];
  end
endmodule

// File: rtl/shf_acc_bank.sv
module shf_acc_bank #(
  parameter int W  = 24,
  parameter int N  = 4,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_sel,
  input  logic [W-1:0]  ld_data,
  input  logic          sh_we,
  input  logic [SW-1:0] sh_dst,
  input  logic [W-1:0]  sh_data,
  input  logic [SW-1:0] src_sel,
  output logic [W-1:0]  src_data,
  input  logic [SW-1:0] rd_sel,
  output logic [W-1:0]  rd_data,
  output logic [N*W-1:0] acc_flat
);
  logic [W-1:0] acc_q [N];

  for (genvar g = 0; g < N; g++) begin : g_acc
    logic [W-1:0] nxt;
    logic         en;
    always_comb begin
      en  = 1'b0;
      nxt = acc_q[g];
      if (sh_we && (sh_dst == SW'(g))) begin
        en  = 1'b1;
        nxt = sh_data;
      end else if (ld_en && (ld_sel == SW'(g))) begin
        en  = 1'b1;
        nxt = ld_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc_q[g] <= '0;
      else if (en) acc_q[g] <= nxt;
    end

    assign acc_flat[g*W +: W] = acc_q[g];
  end

  always_comb begin
    src_data = acc_q[src_sel];
    rd_data  = acc_q[rd_sel];
  end
endmodule

// File: rtl/shf_carry_flag.sv
module shf_carry_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sh_we,
  input  logic sh_c,
  input  logic ld_en,
  input  logic ld_val,
  output logic c_q
);
  logic c_nxt;
  logic c_en;

  always_comb begin
    c_en  = sh_we | ld_en;
    c_nxt = sh_we ? sh_c : ld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    c_q <= 1'b0;
    else if (c_en) c_q <= c_nxt;
  end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int W      = ACC_W,
  parameter int N      = ACC_N,
  parameter int D_SHRT = DIST_S,
  parameter int D_LONG = DIST_L,
  localparam int SW    = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_sel,
  input  logic [W-1:0]  ld_data,
  input  logic          c_ld_en,
  input  logic          c_ld_val,
  input  logic          sh_en,
  input  logic          t_flag,
  input  logic [SW-1:0] sh_src,
  input  logic [SW-1:0] sh_dst,
  input  logic          sh_left,
  input  logic          sh_by8,
  input  logic          sh_thru,
  input  logic [SW-1:0] rd_sel,
  output logic [W-1:0]  rd_data,
  output logic          carry
);
  logic          rst_s;
  logic          exec;
  shf_cmd_t      cmd;
  logic [W-1:0]  src_val;
  logic [W-1:0]  sh_res;
  logic          sh_co;
  logic [N*W-1:0] acc_flat;

  always_comb begin
    exec     = sh_en & t_flag;
    cmd.left = sh_left;
    cmd.by8  = sh_by8;
    cmd.thru = sh_thru;
  end

  shf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s)
  );

  shf_acc_bank #(.W(W), .N(N), .SW(SW)) u_bank (
    .clk(clk), .rst_n(rst_s),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .sh_we(exec), .sh_dst(sh_dst), .sh_data(sh_res),
    .src_sel(sh_src), .src_data(src_val),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .acc_flat(acc_flat)
  );

  shf_barrel #(.W(W), .D_SHRT(D_SHRT), .D_LONG(D_LONG)) u_shift (
    .src(src_val), .cin(carry), .cmd(cmd), .res(sh_res), .cout(sh_co)
  );

  shf_carry_flag u_flag (
    .clk(clk), .rst_n(rst_s),
    .sh_we(exec), .sh_c(sh_co),
    .ld_en(c_ld_en), .ld_val(c_ld_val),
    .c_q(carry)
  );
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
  parameter int W  = 24,
  parameter int N  = 4,
  parameter int SW = $clog2(N)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ld_en,
  input logic [SW-1:0]  ld_sel,
  input logic [W-1:0]   ld_data,
  input logic           c_ld_en,
  input logic           c_ld_val,
  input logic           sh_en,
  input logic           t_flag,
  input logic [SW-1:0]  sh_src,
  input logic [SW-1:0]  sh_dst,
  input logic           sh_left,
  input logic           sh_thru,
  input logic [N*W-1:0] acc_flat,
  input logic           carry
);
  logic [W-1:0] acc_a [N];
  logic         go;

  for (genvar g = 0; g < N; g++) begin : g_unf
    assign acc_a[g] = acc_flat[g*W +: W];
  end

  assign go = sh_en & t_flag;

  // R2
  a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !(go && sh_dst == ld_sel)) |=> acc_a[$past(ld_sel)] == $past(ld_data));

  // R3
  a_r3_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !sh_left && !sh_thru) |=> acc_a[$past(sh_dst)][W-1] == $past(acc_a[sh_src][W-1]));

  // R4
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (go && sh_left && !sh_thru) |=> acc_a[$past(sh_dst)][0] == 1'b0);

  // R6
  a_r6_carry_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (go && sh_thru && !sh_left) |=> acc_a[$past(sh_dst)][W-1] == $past(carry));

  // R8
  a_r8_t_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_en && !t_flag && !ld_en && !c_ld_en) |=> ($stable(acc_flat) && $stable(carry)));

  // R11
  a_r11_carry_load: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ld_en && !go) |=> carry == $past(c_ld_val));
endmodule

bind shf_unit shf_unit_chk #(.W(W), .N(N), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_s),
  .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
  .c_ld_en(c_ld_en), .c_ld_val(c_ld_val),
  .sh_en(sh_en), .t_flag(t_flag), .sh_src(sh_src), .sh_dst(sh_dst),
  .sh_left(sh_left), .sh_thru(sh_thru),
  .acc_flat(acc_flat), .carry(carry)
);

// File: tb/sim_shf_unit.sv
module sim_shf_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [23:0] ld_data = '0;
  logic        c_ld_en = 1'b0;
  logic        c_ld_val = 1'b0;
  logic        sh_en = 1'b0;
  logic        t_flag = 1'b0;
  logic [1:0]  sh_src = '0;
  logic [1:0]  sh_dst = '0;
  logic        sh_left = 1'b0;
  logic        sh_by8 = 1'b0;
  logic        sh_thru = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [23:0] rd_data;
  logic        carry;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shf_unit u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .c_ld_en(c_ld_en), .c_ld_val(c_ld_val), .sh_en(sh_en), .t_flag(t_flag),
    .sh_src(sh_src), .sh_dst(sh_dst), .sh_left(sh_left), .sh_by8(sh_by8),
    .sh_thru(sh_thru), .rd_sel(rd_sel), .rd_data(rd_data), .carry(carry)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  function automatic logic [24:0] ref_shift(logic [23:0] v, logic c, logic lft, logic b8, logic th);
    int n;
    logic [23:0] r;
    logic co;
    n = b8 ? 8 : 1;
    if (lft) begin
      r = v << n;
      if (th && c) r = r | ((24'd1 << n) - 24'd1);
      co = v[24-n];
    end else begin
      if (th) begin
        r = v >> n;
        if (c) r = r | ~(24'hFFFFFF >> n);
      end else begin
        r = $signed(v) >>> n;
      end
      co = v[n-1];
    end
    return {co, r};
  endfunction

  function automatic logic [23:0] pat(int k);
    case (k)
      0: return 24'h800000;
      1: return 24'h7FFFFF;
      2: return 24'hFFFFFF;
      3: return 24'h000001;
      4: return 24'h000000;
      default: return 24'((k * 32'h9E3779) ^ (k << 7));
    endcase
  endfunction

  task automatic load(input logic [1:0] s, input logic [23:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = s; ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic setc(input logic v);
    @(negedge clk);
    c_ld_en = 1'b1; c_ld_val = v;
    @(negedge clk);
    c_ld_en = 1'b0;
  endtask

  task automatic shift(input logic [1:0] s, input logic [1:0] d, input logic l,
                       input logic b8, input logic th, input logic t);
    @(negedge clk);
    sh_en = 1'b1; t_flag = t; sh_src = s; sh_dst = d;
    sh_left = l; sh_by8 = b8; sh_thru = th;
    @(negedge clk);
    sh_en = 1'b0; t_flag = 1'b0;
  endtask

  function automatic string req_of(logic l, logic th);
    if (th) return "R6";
    return l ? "R4" : "R3";
  endfunction

  initial begin
    logic [24:0] e;
    logic [24:0] e2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i); #1;
      chk("R1 acc", rd_data, 24'h0);
    end
    chk("R1 carry", {23'h0, carry}, 24'h0);

    // R2: load and read back
    for (int i = 0; i < 4; i++) load(2'(i), pat(i + 10));
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i); #1;
      chk("R2 load", rd_data, pat(i + 10));
    end

    // R3 R4 R5 R6 R9: sweep patterns, all commands, both carry inputs
    for (int k = 0; k < 24; k++) begin
      for (int op = 0; op < 8; op++) begin
        for (int c = 0; c < 2; c++) begin
          logic [1:0] s;
          logic [1:0] d;
          logic [23:0] other;
          s = 2'(k);
          d = 2'(k + op + c);
          other = pat(k + 40);
          if (d != s) load(d, other);
          load(s, pat(k));
          setc(c[0]);
          shift(s, d, op[0], op[1], op[2], 1'b1);
          e = ref_shift(pat(k), c[0], op[0], op[1], op[2]);
          rd_sel = d; #1;
          chk(req_of(op[0], op[2]), rd_data, e[23:0]);
          chk("R5 carry out", {23'h0, carry}, {23'h0, e[24]});
          if (d != s) begin
            rd_sel = s; #1;
            chk("R9 source kept", rd_data, pat(k));
          end
        end
      end
    end

    // R8: T clear leaves everything
    load(2'd1, 24'hA5C3F0);
    setc(1'b1);
    shift(2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    rd_sel = 2'd1; #1;
    chk("R8 acc unchanged", rd_data, 24'hA5C3F0);
    chk("R8 carry unchanged", {23'h0, carry}, 24'h1);
    setc(1'b0);
    shift(2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    rd_sel = 2'd1; #1;
    chk("R8 src unchanged", rd_data, 24'hA5C3F0);
    chk("R8 carry still 0", {23'h0, carry}, 24'h0);

    // R7: back-to-back shifts chain
    load(2'd0, 24'h812345);
    setc(1'b0);
    @(negedge clk);
    sh_en = 1'b1; t_flag = 1'b1; sh_src = 2'd0; sh_dst = 2'd0;
    sh_left = 1'b0; sh_by8 = 1'b1; sh_thru = 1'b0;
    @(negedge clk);
    sh_left = 1'b1; sh_by8 = 1'b0;
    @(negedge clk);
    sh_en = 1'b0; t_flag = 1'b0;
    e  = ref_shift(24'h812345, 1'b0, 1'b0, 1'b1, 1'b0);
    e2 = ref_shift(e[23:0], e[24], 1'b1, 1'b0, 1'b0);
    rd_sel = 2'd0; #1;
    chk("R7 chained result", rd_data, e2[23:0]);
    chk("R7 chained carry", {23'h0, carry}, {23'h0, e2[24]});

    // R10: load and shift collide on same destination
    load(2'd2, 24'h00F00F);
    @(negedge clk);
    sh_en = 1'b1; t_flag = 1'b1; sh_src = 2'd2; sh_dst = 2'd3;
    sh_left = 1'b1; sh_by8 = 1'b1; sh_thru = 1'b0;
    ld_en = 1'b1; ld_sel = 2'd3; ld_data = 24'h123456;
    @(negedge clk);
    sh_en = 1'b0; t_flag = 1'b0; ld_en = 1'b0;
    rd_sel = 2'd3; #1;
    chk("R10 shift wins", rd_data, 24'hF00F00);
    // R10: different destinations both written
    @(negedge clk);
    sh_en = 1'b1; t_flag = 1'b1; sh_src = 2'd2; sh_dst = 2'd1;
    sh_left = 1'b0; sh_by8 = 1'b0; sh_thru = 1'b0;
    ld_en = 1'b1; ld_sel = 2'd0; ld_data = 24'h654321;
    @(negedge clk);
    sh_en = 1'b0; t_flag = 1'b0; ld_en = 1'b0;
    rd_sel = 2'd1; #1;
    chk("R10 shift written", rd_data, 24'h007807);
    rd_sel = 2'd0; #1;
    chk("R10 load written", rd_data, 24'h654321);

    // R11: carry load alone and colliding with shift
    setc(1'b1);
    chk("R11 carry set", {23'h0, carry}, 24'h1);
    load(2'd0, 24'h000002);
    @(negedge clk);
    sh_en = 1'b1; t_flag = 1'b1; sh_src = 2'd0; sh_dst = 2'd0;
    sh_left = 1'b0; sh_by8 = 1'b0; sh_thru = 1'b0;
    c_ld_en = 1'b1; c_ld_val = 1'b1;
    @(negedge clk);
    sh_en = 1'b0; t_flag = 1'b0; c_ld_en = 1'b0;
    chk("R11 shift carry wins", {23'h0, carry}, 24'h0);
    @(negedge clk);
    c_ld_en = 1'b1; c_ld_val = 1'b1; sh_en = 1'b1; t_flag = 1'b0;
    @(negedge clk);
    c_ld_en = 1'b0; sh_en = 1'b0;
    chk("R11 load with T clear", {23'h0, carry}, 24'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule